// File: doc/BRIEF.md
# Condition flag and conditional branch resolver

This block sits beside the decode stage of a small word-oriented virtual processor. It handles two kinds of instruction. The first kind is a compare, selected by a 3-bit sub-operation. A compare reads one or two literal operand words that the fetch stage has already pulled from the instruction stream. Its result is kept in a single persistent condition flag.

The second kind is a conditional jump, in absolute or relative form. A jump consumes the flag that the most recent compare left behind. It reports whether the branch is taken and which address the instruction pointer must load next. The fetch stage supplies the instruction pointer already advanced past the jump's operand. When the flag is false, the reported target is that sequential address.

A command is presented for one cycle with `cmd_valid`. The flag and the branch result are registered, so they appear one clock later. A compare issued in one cycle can therefore steer a jump issued in the very next cycle.

Top module: `cond_branch_unit`

## Requirements
- R1: Reset (active-low `rst_n`) clears the condition flag to 0 and drives `br_valid` and `br_taken` low.
- R2: Compare sub-operations 0 (equal) and 1 (not equal) set the flag from `opnd_a` against `opnd_b` at full word width. The flag is visible one cycle after the command.
- R3: Sub-operations 2 (less), 3 (less-or-equal), 4 (greater) and 5 (greater-or-equal) set the flag from a two's-complement signed comparison of `opnd_a` against `opnd_b`.
- R4: Sub-operations 6 (zero) and 7 (not zero) set the flag by comparing `opnd_a` with 0. `opnd_b` has no effect on them.
- R5: The flag changes only on a valid compare command (`cmd_op`=0). Idle cycles and jump commands leave it unchanged.
- R6: An absolute conditional jump (`cmd_op`=1) issued while the flag is 1 gives `br_taken`=1 and `br_target`=`opnd_a`, one cycle later.
- R7: A relative conditional jump (`cmd_op`=2) issued while the flag is 1 gives `br_taken`=1 and `br_target` = `ip_next` + signed `opnd_a`, modulo 2^ADDR_W.
- R8: A conditional jump of either form issued while the flag is 0 gives `br_taken`=0 and `br_target`=`ip_next`.
- R9: `br_valid` is high for exactly the one cycle that follows each valid jump command, and low otherwise.
- R10: Command code `cmd_op`=3 is reserved. It changes neither the flag nor any branch output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 compare, 1 absolute jump, 2 relative jump, 3 reserved |
| test_sel | input | 3 | Compare sub-operation (see R2 to R4) |
| opnd_a | input | WORD_W | First fetched operand word, or the jump address/offset |
| opnd_b | input | WORD_W | Second fetched operand word |
| ip_next | input | ADDR_W | Instruction pointer already past the jump operand |
| cond_flag | output | 1 | Persistent condition flag |
| br_valid | output | 1 | Branch result is valid this cycle |
| br_taken | output | 1 | Conditional jump is taken |
| br_target | output | ADDR_W | Next instruction pointer value |

## Verification
The bound checker watches several properties on every cycle:
- the flag is held through idle, jump and reserved cycles;
- `br_valid` follows jump commands one for one;
- a taken branch always needs a set flag at issue;
- an untaken jump falls through to `ip_next`;
- an absolute taken target equals the issued operand;
- the zero test follows its single operand.

Some properties only the bench scenarios show, because they need chosen operand values. These are the signed ordering at the word's sign boundary, `opnd_b` being ignored by the zero tests, and relative targets that wrap around the address space. The same holds for a compare immediately followed by a jump that uses the fresh flag.

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [2:0]        test_sel,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [ADDR_W-1:0] ip_next,
  output logic              cond_flag,
  output logic              br_valid,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target
);
  localparam logic [1:0] OP_TEST = 2'd0;
  localparam logic [1:0] OP_JABS = 2'd1;
  localparam logic [1:0] OP_JREL = 2'd2;

  logic              is_test, is_jump;
  logic              test_res;
  logic [ADDR_W-1:0] abs_addr, rel_ofs, taken_addr;
  logic              eq, lt, a_zero;

  assign is_test = cmd_valid && cmd_op == OP_TEST;
  assign is_jump = cmd_valid && (cmd_op == OP_JABS || cmd_op == OP_JREL);

  assign eq     = opnd_a == opnd_b;
  assign lt     = $signed(opnd_a) < $signed(opnd_b);
  assign a_zero = opnd_a == '0;

  always_comb begin
    case (test_sel)
      3'd0:    test_res = eq;
      3'd1:    test_res = !eq;
      3'd2:    test_res = lt;
      3'd3:    test_res = lt || eq;
      3'd4:    test_res = !(lt || eq);
      3'd5:    test_res = !lt;
      3'd6:    test_res = a_zero;
      default: test_res = !a_zero;
    endcase
  end

  generate
    if (WORD_W >= ADDR_W) begin : g_narrow
      assign abs_addr = opnd_a[ADDR_W-1:0];
      assign rel_ofs  = opnd_a[ADDR_W-1:0];
    end else begin : g_widen
      assign abs_addr = {{(ADDR_W-WORD_W){1'b0}}, opnd_a};
      assign rel_ofs  = {{(ADDR_W-WORD_W){opnd_a[WORD_W-1]}}, opnd_a};
    end
  endgenerate

  assign taken_addr = (cmd_op == OP_JABS) ? abs_addr : ip_next + rel_ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_flag <= 1'b0;
      br_valid  <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
    end else begin
      if (is_test) cond_flag <= test_res;
      br_valid <= is_jump;
      br_taken <= is_jump && cond_flag;
      if (is_jump) br_target <= cond_flag ? taken_addr : ip_next;
    end
  end
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [2:0]        test_sel,
  input logic [WORD_W-1:0] opnd_a,
  input logic [ADDR_W-1:0] ip_next,
  input logic              cond_flag,
  input logic              br_valid,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target
);
  logic jump_cmd, test_cmd;
  assign jump_cmd = cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2);
  assign test_cmd = cmd_valid && cmd_op == 2'd0;

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !test_cmd |=> $stable(cond_flag)); // R5
  AST_VALID_FOLLOWS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    jump_cmd |=> br_valid); // R9
  AST_VALID_ONLY_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_cmd |=> !br_valid); // R10
  AST_TAKEN_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    jump_cmd && !cond_flag |=> !br_taken && br_target == $past(ip_next)); // R8
  AST_ABS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 && cond_flag |=> br_taken && br_target == $past(opnd_a[ADDR_W-1:0])); // R6
  AST_ZERO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    test_cmd && test_sel == 3'd6 |=> cond_flag == ($past(opnd_a) == '0)); // R4
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .test_sel(test_sel), .opnd_a(opnd_a), .ip_next(ip_next),
  .cond_flag(cond_flag), .br_valid(br_valid), .br_taken(br_taken),
  .br_target(br_target)
);

// File: tb/tb_cond_branch_unit.sv
module tb_cond_branch_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [2:0]  test_sel = 0;
  logic [31:0] opnd_a = 0, opnd_b = 0, ip_next = 0;
  logic        cond_flag, br_valid, br_taken;
  logic [31:0] br_target;

  cond_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .test_sel(test_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .ip_next(ip_next),
    .cond_flag(cond_flag), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  req;
    logic        flag;
    logic        bv;
    logic        tk;
    logic        chk_tgt;
    logic [31:0] tgt;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   model_flag = 0;
  bit   mon_en = 0;
  bit   done = 0;

  task automatic drive(input logic [1:0] op, input logic [2:0] sel,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] ip, input bit v, input int req);
    exp_t e;
    bit   res;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; test_sel = sel;
    opnd_a = a; opnd_b = b; ip_next = ip;
    e.req = 8'(req); e.bv = 0; e.tk = 0; e.chk_tgt = 0; e.tgt = '0;
    if (v && op == 2'd0) begin
      case (sel)
        3'd0: res = (a == b);
        3'd1: res = (a != b);
        3'd2: res = ($signed(a) <  $signed(b));
        3'd3: res = ($signed(a) <= $signed(b));
        3'd4: res = ($signed(a) >  $signed(b));
        3'd5: res = ($signed(a) >= $signed(b));
        3'd6: res = (a == 0);
        default: res = (a != 0);
      endcase
      model_flag = res;
    end else if (v && (op == 2'd1 || op == 2'd2)) begin
      e.bv = 1; e.tk = model_flag; e.chk_tgt = 1;
      if (!model_flag) e.tgt = ip;
      else if (op == 2'd1) e.tgt = a;
      else e.tgt = ip + a;
    end
    e.flag = model_flag;
    q.push_back(e);
  endtask

  task automatic idle(input int req);
    drive(2'd0, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0, req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_en && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (cond_flag !== e.flag || br_valid !== e.bv || br_taken !== e.tk ||
            (e.chk_tgt && br_target !== e.tgt)) begin
          errors++;
          $display("FAIL R%0d: flag=%0b valid=%0b taken=%0b target=%h expected flag=%0b valid=%0b taken=%0b target=%h",
                   e.req, cond_flag, br_valid, br_taken, br_target, e.flag, e.bv, e.tk, e.tgt);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1
    if (cond_flag !== 0 || br_valid !== 0 || br_taken !== 0) begin
      errors++;
      $display("FAIL R1: flag=%0b valid=%0b taken=%0b expected 0 0 0", cond_flag, br_valid, br_taken);
    end
    rst_n = 1;
    mon_en = 1;

    drive(2'd0, 3'd0, 32'd5, 32'd5, 0, 1, 2);                 // R2 equal -> 1
    drive(2'd1, 3'd0, 32'h100, 0, 32'h40, 1, 6);             // R6 taken absolute
    drive(2'd0, 3'd1, 32'd5, 32'd5, 0, 1, 2);                 // R2 not equal -> 0
    drive(2'd1, 3'd0, 32'h100, 0, 32'h44, 1, 8);             // R8 falls through
    drive(2'd2, 3'd0, 32'hFFFF_FFF8, 0, 32'h60, 1, 8);       // R8 relative, flag 0
    drive(2'd0, 3'd2, 32'hFFFF_FFFF, 32'd1, 0, 1, 3);        // R3 -1 < 1
    drive(2'd0, 3'd3, 32'd7, 32'd7, 0, 1, 3);                // R3 le equal
    drive(2'd0, 3'd4, 32'd1, 32'hFFFF_FFFF, 0, 1, 3);        // R3 1 > -1
    drive(2'd0, 3'd5, 32'hFFFF_FFFB, 32'hFFFF_FFFC, 0, 1, 3); // R3 -5 >= -4 -> 0
    drive(2'd0, 3'd2, 32'h8000_0000, 32'h7FFF_FFFF, 0, 1, 3); // R3 sign boundary
    drive(2'd2, 3'd0, 32'hFFFF_FFF8, 0, 32'h20, 1, 7);       // R7 back by 8
    drive(2'd0, 3'd6, 32'd0, 32'd9, 0, 1, 4);                // R4 zero, b ignored
    drive(2'd2, 3'd0, 32'h20, 0, 32'hFFFF_FFF0, 1, 7);       // R7 wraps
    idle(5);                                                 // R5 hold
    idle(9);                                                 // R9 no valid
    drive(2'd3, 3'd0, 32'd0, 32'd0, 32'h80, 1, 10);          // R10 reserved
    drive(2'd0, 3'd7, 32'd0, 32'd5, 0, 1, 4);                // R4 nonzero -> 0
    drive(2'd3, 3'd7, 32'd1, 32'd1, 32'h80, 1, 10);          // R10 reserved
    drive(2'd2, 3'd0, 32'h10, 0, 32'h90, 1, 8);              // R8 flag still 0
    drive(2'd0, 3'd7, 32'd3, 32'd0, 0, 1, 4);                // R4 nonzero -> 1
    drive(2'd0, 3'd5, 32'd2, 32'd2, 0, 0, 5);                // R5 invalid compare ignored
    drive(2'd1, 3'd0, 32'h0000_0ABC, 0, 32'h10, 1, 6);       // R6 taken
    drive(2'd1, 3'd0, 32'h0000_0DEF, 0, 32'h14, 1, 9);       // R9 back-to-back jumps
    idle(9);
    idle(5);
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results never observed, expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule